// File: doc/BRIEF.md
# Packet Timestamp Capture Queue

This block records the start-of-packet time of precision-time-protocol event messages on the transmit and receive paths. A packet parser upstream raises a one-cycle strobe with the message's fields: direction, 4-bit message type, 16-bit sequence id and the 32-bit seconds and 32-bit nanoseconds of the local clock at the start of the frame. The block keeps each accepted event in a small first-in first-out queue.

Software sees a status bit that is set while at least one capture waits in the queue. It takes one entry out through a control handshake. A start write freezes the entry at the head. Six 16-bit words of that entry can then be read through a word selector. An end write followed by a zero write releases the entry. If the queue is already full, a new capture is dropped and a sticky overflow flag is set.

Top module: `pkt_ts_capture`

## Requirements
- R1: After reset, `sop_pending` is 0, `overflow` is 0 and `rd_word` is 0.
- R2: A receive strobe is captured only while `rx_slice_en` is 1. With `rx_slice_en` at 0, a receive strobe leaves `sop_pending` low on an empty queue.
- R3: A transmit strobe (`sop_is_tx`=1) is captured only when both `tx_slice_en` and `tx_capture_en` are 1. If either is 0, the strobe is dropped.
- R4: Only message types 0 (sync), 1 (delay request), 2 (peer-delay request) and 3 (peer-delay response) are captured. Strobes carrying types 4 to 15 are ignored.
- R5: `sop_pending` rises at the clock edge that accepts a capture into an empty queue. It falls at the edge that releases the last entry.
- R6: A `ctrl_wdata`=2'b01 write while `sop_pending` is 1 freezes the head entry. One cycle after `word_sel` is applied, `rd_word` shows the selected word: 0 = nanoseconds[15:0], 1 = nanoseconds[31:16], 2 = seconds[15:0], 3 = seconds[31:16], 4 = sequence id. While no entry is frozen, `rd_word` is 0.
- R7: Word 5 (the info word) holds the message type in bits 15:12 and a 1 in bit 11 for a transmit capture. Bits 10:0 are 0.
- R8: A `ctrl_wdata`=2'b10 write after a start, followed by a `ctrl_wdata`=2'b00 write, releases the frozen entry from the queue. A zero write with no end write before it has no effect: the entry stays frozen and readable.
- R9: Entries are read out in the order they were captured, with transmit and receive captures interleaved in one queue.
- R10: A capture arriving while the queue holds DEPTH entries (default 4) is dropped and sets `overflow`. `overflow` stays set until reset, and the stored entries are unchanged.
- R11: Captures accepted while an entry is frozen do not change the frozen entry's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_slice_en | input | 1 | Receive capture enable |
| tx_slice_en | input | 1 | Transmit path enable |
| tx_capture_en | input | 1 | Transmit capture enable, needed together with tx_slice_en |
| sop_valid | input | 1 | One-cycle start-of-packet strobe from the parser |
| sop_is_tx | input | 1 | Strobe direction: 1 = transmit |
| sop_msg_type | input | 4 | Event message type |
| sop_seq_id | input | 16 | Message sequence id |
| sop_sec | input | 32 | Seconds at start of packet |
| sop_nsec | input | 32 | Nanoseconds at start of packet |
| ctrl_we | input | 1 | Readout control write strobe |
| ctrl_wdata | input | 2 | Control value: bit 0 start, bit 1 end, 0 releases |
| word_sel | input | 3 | Selects the word of the frozen entry |
| rd_word | output | 16 | Registered readout word |
| sop_pending | output | 1 | At least one capture is queued |
| overflow | output | 1 | Sticky: a capture was dropped on a full queue |

## Verification
A queue pointer or count that drifts shows up as words belonging to the wrong capture, or as `sop_pending` staying high or dropping early. This is visible at the first readout after the fault, which is one cycle after `word_sel` changes. A readout state that skips the end step shows up as an entry lost on a bare zero write. A head register that follows the queue while an entry is frozen shows up as a changed word in the very next read. Filter errors show up as a stray `sop_pending` on an otherwise empty queue at the next edge.

// File: rtl/pts_pkg.sv
package pts_pkg;
  localparam int SEC_W  = 32;
  localparam int NS_W   = 32;
  localparam int SEQ_W  = 16;
  localparam int TYPE_W = 4;
  localparam int WORD_W = 16;
  localparam int SEL_W  = 3;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [NS_W-1:0]   nsec;
    logic [SEQ_W-1:0]  seq;
    logic [TYPE_W-1:0] mtype;
    logic              is_tx;
  } pts_entry_t;

  localparam int ENTRY_W = $bits(pts_entry_t);

  typedef enum logic [1:0] {RO_IDLE, RO_HELD, RO_CLOSING} ro_state_t;

  function automatic logic [WORD_W-1:0] pick_word(pts_entry_t e, logic [SEL_W-1:0] sel);
    logic [WORD_W-1:0] w;
    case (sel)
      3'd0:    w = e.nsec[15:0];
      3'd1:    w = e.nsec[31:16];
      3'd2:    w = e.sec[15:0];
      3'd3:    w = e.sec[31:16];
      3'd4:    w = e.seq;
      3'd5:    w = {e.mtype, e.is_tx, 11'b0};
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/pts_event_filter.sv
module pts_event_filter
  import pts_pkg::*;
#(
  parameter logic [15:0] EVENT_MASK = 16'h000F
) (
  input  logic              rx_slice_en,
  input  logic              tx_slice_en,
  input  logic              tx_capture_en,
  input  logic              sop_valid,
  input  logic              sop_is_tx,
  input  logic [TYPE_W-1:0] sop_msg_type,
  output logic              accept
);
  logic dir_ok;
  always_comb begin
    dir_ok = sop_is_tx ? (tx_slice_en && tx_capture_en) : rx_slice_en;
    accept = sop_valid && dir_ok && EVENT_MASK[sop_msg_type];
  end
endmodule

// File: rtl/pts_queue.sv
module pts_queue
  import pts_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  pts_entry_t wdata,
  input  logic       pop,
  output pts_entry_t head,
  output logic       head_valid,
  output logic       overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, rd_ptr_nx;
  logic [CW-1:0] count;
  logic full, do_push, do_pop;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full      = (count == CW'(DEPTH));
    do_push   = push && !full;
    do_pop    = pop && (count != '0);
    rd_ptr_nx = do_pop ? bump(rd_ptr) : rd_ptr;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (do_push && (wr_ptr == rd_ptr_nx)) head <= wdata;
    else                                  head <= mem[rd_ptr_nx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      head_valid <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      rd_ptr <= rd_ptr_nx;
      count  <= count + CW'(do_push) - CW'(do_pop);
      head_valid <= ((count + CW'(do_push) - CW'(do_pop)) != '0);
      if (push && full) overflow <= 1'b1;
    end
  end

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  assert_pending_after_push_R5: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> head_valid);
endmodule

// File: rtl/pts_readout.sv
module pts_readout
  import pts_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [1:0]        ctrl_wdata,
  input  logic [SEL_W-1:0]  word_sel,
  input  pts_entry_t        head,
  input  logic              head_valid,
  output logic              pop,
  output logic [WORD_W-1:0] rd_word
);
  ro_state_t  state_q;
  pts_entry_t latch_q;

  always_comb pop = ctrl_we && (ctrl_wdata == 2'b00) && (state_q == RO_CLOSING);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RO_IDLE;
      latch_q <= '0;
      rd_word <= '0;
    end else begin
      rd_word <= (state_q != RO_IDLE) ? pick_word(latch_q, word_sel) : '0;
      if (ctrl_we) begin
        case (state_q)
          RO_IDLE: if (ctrl_wdata == 2'b01 && head_valid) begin
            latch_q <= head;
            state_q <= RO_HELD;
          end
          RO_HELD: if (ctrl_wdata[1]) state_q <= RO_CLOSING;
          RO_CLOSING: if (ctrl_wdata == 2'b00) begin
            state_q <= RO_IDLE;
            latch_q <= '0;
          end
          default: state_q <= RO_IDLE;
        endcase
      end
    end
  end

  assert_release_has_entry_R8: assert property (@(posedge clk) disable iff (rst)
    pop |-> head_valid);
  assert_held_in_queue_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q != RO_IDLE) |-> head_valid);
  assert_frozen_stable_R11: assert property (@(posedge clk) disable iff (rst)
    ((state_q != RO_IDLE) && ($past(state_q) != RO_IDLE)) |-> $stable(latch_q));
endmodule

// File: rtl/pkt_ts_capture.sv
module pkt_ts_capture
  import pts_pkg::*;
#(
  parameter int          DEPTH      = 4,
  parameter logic [15:0] EVENT_MASK = 16'h000F
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_slice_en,
  input  logic        tx_slice_en,
  input  logic        tx_capture_en,
  input  logic        sop_valid,
  input  logic        sop_is_tx,
  input  logic [3:0]  sop_msg_type,
  input  logic [15:0] sop_seq_id,
  input  logic [31:0] sop_sec,
  input  logic [31:0] sop_nsec,
  input  logic        ctrl_we,
  input  logic [1:0]  ctrl_wdata,
  input  logic [2:0]  word_sel,
  output logic [15:0] rd_word,
  output logic        sop_pending,
  output logic        overflow
);
  logic       accept, pop;
  pts_entry_t in_entry, head;

  always_comb begin
    in_entry.sec   = sop_sec;
    in_entry.nsec  = sop_nsec;
    in_entry.seq   = sop_seq_id;
    in_entry.mtype = sop_msg_type;
    in_entry.is_tx = sop_is_tx;
  end

  pts_event_filter #(.EVENT_MASK(EVENT_MASK)) u_filter (
    .rx_slice_en(rx_slice_en), .tx_slice_en(tx_slice_en), .tx_capture_en(tx_capture_en),
    .sop_valid(sop_valid), .sop_is_tx(sop_is_tx), .sop_msg_type(sop_msg_type),
    .accept(accept));

  pts_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(accept), .wdata(in_entry), .pop(pop),
    .head(head), .head_valid(sop_pending), .overflow(overflow));

  pts_readout u_readout (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .word_sel(word_sel), .head(head), .head_valid(sop_pending),
    .pop(pop), .rd_word(rd_word));

  assert_tx_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && sop_is_tx) |-> (tx_slice_en && tx_capture_en));
  assert_rx_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && !sop_is_tx) |-> rx_slice_en);
endmodule

// File: tb/pkt_ts_capture_bench.sv
module pkt_ts_capture_bench;
  import pts_pkg::*;

  logic clk = 0, rst = 1;
  logic rx_slice_en = 0, tx_slice_en = 0, tx_capture_en = 0;
  logic sop_valid = 0, sop_is_tx = 0;
  logic [3:0] sop_msg_type = 0;
  logic [15:0] sop_seq_id = 0;
  logic [31:0] sop_sec = 0, sop_nsec = 0;
  logic ctrl_we = 0;
  logic [1:0] ctrl_wdata = 0;
  logic [2:0] word_sel = 0;
  logic [15:0] rd_word;
  logic sop_pending, overflow;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  pts_entry_t sb[$];

  always #10 clk = ~clk;

  pkt_ts_capture u_pkt_ts_capture (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(pts_entry_t e, int w);
    case (w)
      0: return e.nsec[15:0];
      1: return e.nsec[31:16];
      2: return e.sec[15:0];
      3: return e.sec[31:16];
      4: return e.seq;
      default: return {e.mtype, e.is_tx, 11'h000};
    endcase
  endfunction

  // driver: pushes the expected item when the rules say it is kept
  task automatic capture(bit tx, logic [3:0] mt, logic [15:0] seq, logic [31:0] s, logic [31:0] ns);
    pts_entry_t e;
    bit keep;
    e.sec = s; e.nsec = ns; e.seq = seq; e.mtype = mt; e.is_tx = tx;
    keep = (mt < 4) && (tx ? (tx_slice_en && tx_capture_en) : rx_slice_en) && (sb.size() < 4);
    if (keep) sb.push_back(e);
    sop_valid = 1; sop_is_tx = tx; sop_msg_type = mt; sop_seq_id = seq; sop_sec = s; sop_nsec = ns;
    @(negedge clk);
    sop_valid = 0;
  endtask

  task automatic ctrl_write(logic [1:0] v);
    ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic read_words(string req, pts_entry_t e);
    for (int w = 0; w < 6; w++) begin
      word_sel = 3'(w);
      @(negedge clk);
      check(req, {16'h0, rd_word}, {16'h0, exp_word(e, w)});
    end
  endtask

  // monitor: pops the scoreboard and compares one readout
  task automatic read_entry(string req);
    pts_entry_t e;
    e = sb.pop_front();
    ctrl_write(2'b01);
    read_words(req, e);
    ctrl_write(2'b10);
    ctrl_write(2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    pts_entry_t e;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    check("R1 pending", {31'h0, sop_pending}, 0);
    check("R1 overflow", {31'h0, overflow}, 0);
    check("R1 rd_word", {16'h0, rd_word}, 0);
    // R2: rx disabled
    capture(0, 4'd0, 16'h0001, 32'h1, 32'h2);
    check("R2 rx disabled", {31'h0, sop_pending}, 0);
    rx_slice_en = 1; tx_slice_en = 1;
    // R3: tx missing capture enable
    capture(1, 4'd0, 16'h0002, 32'h3, 32'h4);
    check("R3 tx cap off", {31'h0, sop_pending}, 0);
    tx_slice_en = 0; tx_capture_en = 1;
    capture(1, 4'd1, 16'h0003, 32'h3, 32'h4);
    check("R3 tx slice off", {31'h0, sop_pending}, 0);
    tx_slice_en = 1;
    // R4
    capture(0, 4'd4, 16'h0004, 32'h5, 32'h6);
    capture(1, 4'd9, 16'h0005, 32'h5, 32'h6);
    check("R4 type ignored", {31'h0, sop_pending}, 0);
    // R6 unfrozen reads zero
    word_sel = 3'd4; @(negedge clk);
    check("R6 unfrozen", {16'h0, rd_word}, 0);
    // R2, R5, R6 single rx capture
    capture(0, 4'd0, 16'hA5C3, 32'h1234_5678, 32'h3B9A_C9FF);
    check("R5 pending rise", {31'h0, sop_pending}, 1);
    read_entry("R6 rx words");
    check("R5 pending fall", {31'h0, sop_pending}, 0);
    // R9, R7 interleaved order
    capture(1, 4'd3, 16'h0101, 32'hDEAD_BEEF, 32'h0000_0010);
    capture(0, 4'd1, 16'h0202, 32'h0000_0001, 32'h0BAD_F00D);
    capture(1, 4'd2, 16'hFFFF, 32'hFFFF_FFFF, 32'h3B9A_C9FF);
    read_entry("R9 order first R7");
    read_entry("R9 order second");
    read_entry("R9 order third R7");
    check("R5 empty again", {31'h0, sop_pending}, 0);
    // R8 bare zero write ignored
    capture(1, 4'd0, 16'h7777, 32'h11, 32'h22);
    e = sb.pop_front();
    ctrl_write(2'b01);
    ctrl_write(2'b00);
    check("R8 still pending", {31'h0, sop_pending}, 1);
    read_words("R8 still frozen", e);
    ctrl_write(2'b10);
    ctrl_write(2'b00);
    check("R8 released", {31'h0, sop_pending}, 0);
    word_sel = 3'd0; @(negedge clk);
    check("R8 unfrozen after release", {16'h0, rd_word}, 0);
    // R11 capture while frozen
    capture(0, 4'd2, 16'h1111, 32'hAAAA_0001, 32'h5555_0002);
    e = sb.pop_front();
    ctrl_write(2'b01);
    capture(1, 4'd3, 16'h2222, 32'hBBBB_0003, 32'h6666_0004);
    read_words("R11 frozen unchanged", e);
    ctrl_write(2'b10);
    ctrl_write(2'b00);
    check("R11 next pending", {31'h0, sop_pending}, 1);
    read_entry("R11 next entry");
    // R10 overflow
    for (int i = 0; i < 5; i++)
      capture(i[0], 4'(i % 4), 16'(16'h3000 + i), 32'(i * 7 + 1), 32'(i * 13 + 2));
    check("R10 overflow set", {31'h0, overflow}, 1);
    check("R10 kept entries", sb.size(), 4);
    for (int i = 0; i < 4; i++) read_entry("R10 stored entry");
    check("R10 drained", {31'h0, sop_pending}, 0);
    check("R10 overflow sticky", {31'h0, overflow}, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule